// File: doc/BRIEF.md
# Multiply/Divide Step ALU

This block is the arithmetic core of a microcoded datapath. It holds two operand registers (A, loaded from the first bus, and B, loaded from the second bus), an accumulator whose value goes to the register file and back onto a bus, a small loop counter D, and two registered condition flags. Each cycle an external sequencer may present a 4-bit function code with an execute strobe, a signed 8-bit operand taken from the microword, and a 4-bit internal-control field that is honoured only when the microword is of the arithmetic-extension type.

The basic functions (add, subtract, the three bitwise operations and three shifts) compute the accumulator from A and B. The extra functions are single steps from which a sequencer builds shift-and-add multiplication and restoring division: operand-directed shifts of A and B, a quotient bit entering A from the sign flag, negations, a reverse subtract, and the D counter with load and decrement-and-test. The internal-control field lets an adder input be forced to zero, lets the accumulator be fed back as an addend, and lets B be dropped when the low bit of A is clear. A range check flags operands that do not fit a 16-bit signed value.

Top module: `stepalu`

## Requirements
- R1: After reset, the accumulator, A, B and D read zero, both flags are 0 and the range error is 0.
- R2: With `a_ld` high, A takes `bus1_in` at the clock edge; with `b_ld` high, B takes `bus2_in`. A bus load wins over a shift of the same register in that cycle (code C for A, code D for B), and the losing shift then changes neither the register nor the flags.
- R3: Codes 0 to 4 write the accumulator with x+y, x-y, x AND y, x OR y and x XOR y, where x is A and y is B unless R11 alters them.
- R4: Code 5 shifts x left, code 6 shifts x right with zero fill, code 7 shifts x right with sign fill, each by the low 5 bits of y.
- R5: Code 9 writes y-x, code A writes -x, code B writes -y into the accumulator.
- R6: Code 8, and any cycle with `fn_en` low, leaves the accumulator, A, B, D and the flags unchanged.
- R7: In the cycle after an accumulator-writing operation, `cc0` is 1 if the accumulator is non-zero and 0 if it is zero, and `cc1` equals its sign bit.
- R8: Code C shifts A by the signed operand `uop`: a positive value shifts right with zero fill, a negative value shifts left by its magnitude with the bit entering bit 0 equal to the inverse of the current `cc1`. The flags are then set from the new A by the R7 rule; the accumulator is unchanged.
- R9: Code D shifts B left by a positive `uop` and right with zero fill by a negative one (magnitudes 1 and 16 included); the flags are unchanged.
- R10: Code E loads D with `uop`; code F decrements D and sets `cc0` to 1 if the new D is non-zero and `cc1` to its top bit, so that after loading 17, the seventeenth decrement is the first to clear `cc0`.
- R11: With `ctl_en` high, `ctl` bit 0 forces A's adder input to zero, bit 1 forces y to zero, bit 2 adds the accumulator into x, and bit 3 forces y to zero when bit 0 of A is 0. With `ctl_en` low the field has no effect.
- R12: With `rng_chk` high, if A or B is not a sign-extended 16-bit value, `range_err` rises at the next edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus1_in | input | 32 | Data from the first bus, source for A |
| bus2_in | input | 32 | Data from the second bus, source for B |
| a_ld | input | 1 | Load A from `bus1_in` |
| b_ld | input | 1 | Load B from `bus2_in` |
| fn_en | input | 1 | Execute `fn_code` this cycle |
| fn_code | input | 4 | Function code 0 to F |
| uop | input | 8 | Signed operand from the microword |
| ctl | input | 4 | Internal-control field |
| ctl_en | input | 1 | Microword is of the extension type; enables `ctl` |
| rng_chk | input | 1 | New multiply/divide operands: check their range |
| acc_out | output | 32 | Accumulator, to the register file and the second bus |
| a_out | output | 32 | Register A (quotient / multiplier) |
| b_out | output | 32 | Register B |
| cc0 | output | 1 | Non-zero flag |
| cc1 | output | 1 | Negative flag |
| range_err | output | 1 | Sticky operand range error |

## Verification
A bus load into A and a code-C shift of A can both target A in one cycle, and likewise a load into B and a code-D shift of B. The bench provokes each collision by asserting the load strobe together with the shift function, with known flags beforehand. It judges the outcome by reading back the loaded bus value, not the shifted one, and by confirming the flags are identical to their prior values, which proves the shift was dropped whole.

// File: rtl/stepalu_pkg.sv
package stepalu_pkg;

   typedef enum logic [3:0] {
      FN_ADD  = 4'h0,
      FN_SUB  = 4'h1,
      FN_AND  = 4'h2,
      FN_OR   = 4'h3,
      FN_XOR  = 4'h4,
      FN_SLL  = 4'h5,
      FN_SRL  = 4'h6,
      FN_SRA  = 4'h7,
      FN_NOP  = 4'h8,
      FN_RSUB = 4'h9,
      FN_NEGA = 4'hA,
      FN_NEGB = 4'hB,
      FN_SHA  = 4'hC,
      FN_SHB  = 4'hD,
      FN_DLD  = 4'hE,
      FN_DDEC = 4'hF
   } alu_fn_e;

   // internal-control field bit positions
   localparam int CTL_INH_A  = 0;
   localparam int CTL_INH_B  = 1;
   localparam int CTL_ACC_FB = 2;
   localparam int CTL_CND_B  = 3;

endpackage

// File: rtl/stepalu_opsel.sv
module stepalu_opsel
   import stepalu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a_val,
   input  logic [DW-1:0] b_val,
   input  logic [DW-1:0] acc_val,
   input  logic [3:0]    ctl,
   input  logic          ctl_en,
   output logic [DW-1:0] x_op,
   output logic [DW-1:0] y_op
);

   logic inh_a, inh_b, acc_fb;

   always_comb begin
      inh_a  = ctl_en & ctl[CTL_INH_A];
      inh_b  = ctl_en & (ctl[CTL_INH_B] | (ctl[CTL_CND_B] & ~a_val[0]));
      acc_fb = ctl_en & ctl[CTL_ACC_FB];
      x_op   = (inh_a ? '0 : a_val) + (acc_fb ? acc_val : '0);
      y_op   = inh_b ? '0 : b_val;
   end

endmodule

// File: rtl/stepalu_shift.sv
module stepalu_shift #(
   parameter int DW       = 32,
   parameter int OPW      = 8,
   parameter bit POS_LEFT = 1'b0
) (
   input  logic [DW-1:0]  din,
   input  logic [OPW-1:0] amt,
   input  logic           fill,
   output logic [DW-1:0]  dout
);

   localparam logic [OPW:0] MAG_LIM = DW[OPW:0];

   logic [OPW:0]  mag;
   logic          neg, go_left, too_far;
   logic [DW-1:0] shl, shr;

   generate
      if (POS_LEFT) begin : g_pos_left
         assign go_left = ~neg;
      end else begin : g_pos_right
         assign go_left = neg;
      end
   endgenerate

   always_comb begin
      neg     = amt[OPW-1];
      mag     = neg ? -{amt[OPW-1], amt} : {1'b0, amt};
      too_far = (mag >= MAG_LIM);
      shl     = too_far ? '0 : (din << mag);
      shr     = too_far ? '0 : (din >> mag);
      dout    = go_left ? (shl | {{(DW-1){1'b0}}, fill}) : shr;
   end

endmodule

// File: rtl/stepalu_dcnt.sv
module stepalu_dcnt #(
   parameter int CNTW = 8,
   parameter int OPW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            dec,
   input  logic [OPW-1:0]  val,
   output logic [CNTW-1:0] d_q,
   output logic [CNTW-1:0] d_nx
);

   assign d_nx = d_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    d_q <= '0;
      else if (load) d_q <= CNTW'(val);
      else if (dec)  d_q <= d_nx;
   end

endmodule

// File: rtl/stepalu.sv
module stepalu
   import stepalu_pkg::*;
#(
   parameter int DW   = 32,
   parameter int OPW  = 8,
   parameter int CNTW = 8,
   parameter int CHKW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   bus1_in,
   input  logic [DW-1:0]   bus2_in,
   input  logic            a_ld,
   input  logic            b_ld,
   input  logic            fn_en,
   input  logic [3:0]      fn_code,
   input  logic [OPW-1:0]  uop,
   input  logic [3:0]      ctl,
   input  logic            ctl_en,
   input  logic            rng_chk,
   output logic [DW-1:0]   acc_out,
   output logic [DW-1:0]   a_out,
   output logic [DW-1:0]   b_out,
   output logic            cc0,
   output logic            cc1,
   output logic            range_err
);

   localparam int SHW = $clog2(DW);

   generate
      if (CHKW > DW || CHKW < 2) begin : g_bad_chkw
         $error("stepalu: CHKW must lie in 2..DW");
      end
      if (OPW + 1 <= SHW) begin : g_bad_opw
         $error("stepalu: OPW too narrow to express a full shift");
      end
      if (CNTW < 2) begin : g_bad_cntw
         $error("stepalu: CNTW must be at least 2");
      end
   endgenerate

   alu_fn_e       fn;
   logic [DW-1:0] x_op, y_op, res;
   logic [DW-1:0] sha_out, shb_out;
   logic [CNTW-1:0] d_q, d_nx;
   logic          acc_wr, sha_go, shb_go, d_ld, d_dec;
   logic          fit_a, fit_b;

   assign fn = alu_fn_e'(fn_code);

   stepalu_opsel #(.DW(DW)) u_opsel (
      .a_val(a_out), .b_val(b_out), .acc_val(acc_out),
      .ctl(ctl), .ctl_en(ctl_en), .x_op(x_op), .y_op(y_op)
   );

   stepalu_shift #(.DW(DW), .OPW(OPW), .POS_LEFT(1'b0)) u_sha (
      .din(a_out), .amt(uop), .fill(~cc1), .dout(sha_out)
   );

   stepalu_shift #(.DW(DW), .OPW(OPW), .POS_LEFT(1'b1)) u_shb (
      .din(b_out), .amt(uop), .fill(1'b0), .dout(shb_out)
   );

   stepalu_dcnt #(.CNTW(CNTW), .OPW(OPW)) u_dcnt (
      .clk(clk), .rst_n(rst_n), .load(d_ld), .dec(d_dec),
      .val(uop), .d_q(d_q), .d_nx(d_nx)
   );

   always_comb begin
      unique case (fn)
         FN_ADD:  res = x_op + y_op;
         FN_SUB:  res = x_op - y_op;
         FN_AND:  res = x_op & y_op;
         FN_OR:   res = x_op | y_op;
         FN_XOR:  res = x_op ^ y_op;
         FN_SLL:  res = x_op << y_op[SHW-1:0];
         FN_SRL:  res = x_op >> y_op[SHW-1:0];
         FN_SRA:  res = $unsigned($signed(x_op) >>> y_op[SHW-1:0]);
         FN_RSUB: res = y_op - x_op;
         FN_NEGA: res = -x_op;
         FN_NEGB: res = -y_op;
         default: res = '0;
      endcase
   end

   always_comb begin
      acc_wr = fn_en & (fn != FN_NOP) & (fn_code < 4'hC);
      sha_go = fn_en & (fn == FN_SHA) & ~a_ld;
      shb_go = fn_en & (fn == FN_SHB) & ~b_ld;
      d_ld   = fn_en & (fn == FN_DLD);
      d_dec  = fn_en & (fn == FN_DDEC);
      fit_a  = (&a_out[DW-1:CHKW-1]) | ~(|a_out[DW-1:CHKW-1]);
      fit_b  = (&b_out[DW-1:CHKW-1]) | ~(|b_out[DW-1:CHKW-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_out     <= '0;
         b_out     <= '0;
         acc_out   <= '0;
         cc0       <= 1'b0;
         cc1       <= 1'b0;
         range_err <= 1'b0;
      end else begin
         if (a_ld)        a_out <= bus1_in;
         else if (sha_go) a_out <= sha_out;

         if (b_ld)        b_out <= bus2_in;
         else if (shb_go) b_out <= shb_out;

         if (acc_wr) acc_out <= res;

         if (acc_wr) begin
            cc0 <= |res;
            cc1 <= res[DW-1];
         end else if (sha_go) begin
            cc0 <= |sha_out;
            cc1 <= sha_out[DW-1];
         end else if (d_dec) begin
            cc0 <= |d_nx;
            cc1 <= d_nx[CNTW-1];
         end

         if (rng_chk && !(fit_a && fit_b)) range_err <= 1'b1;
      end
   end

endmodule

// File: rtl/stepalu_chk.sv
module stepalu_chk #(
   parameter int DW   = 32,
   parameter int OPW  = 8,
   parameter int CNTW = 8,
   parameter int CHKW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [DW-1:0]   bus1_in,
   input logic [DW-1:0]   bus2_in,
   input logic            a_ld,
   input logic            b_ld,
   input logic            fn_en,
   input logic [3:0]      fn_code,
   input logic [DW-1:0]   acc_out,
   input logic [DW-1:0]   a_out,
   input logic [DW-1:0]   b_out,
   input logic            cc0,
   input logic            cc1,
   input logic            range_err,
   input logic [CNTW-1:0] d_q
);

   logic acc_op;
   assign acc_op = fn_en && fn_code != 4'h8 && fn_code < 4'hC;

   AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      a_ld |=> a_out == $past(bus1_in)); // R2
   AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      b_ld |=> b_out == $past(bus2_in)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fn_en && !a_ld && !b_ld) |=> ($stable(acc_out) && $stable(a_out) && $stable(b_out) && $stable(cc0) && $stable(cc1))); // R6
   AST_CC0_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc_op |=> cc0 == (acc_out != '0)); // R7
   AST_CC1_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc_op |=> cc1 == acc_out[DW-1]); // R7
   AST_ASHIFT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_en && fn_code == 4'hC) |=> $stable(acc_out)); // R8
   AST_BSHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_en && fn_code == 4'hD) |=> ($stable(cc0) && $stable(cc1))); // R9
   AST_D_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_en && fn_code == 4'hF) |=> d_q == CNTW'($past(d_q) - 1'b1)); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> range_err); // R12

endmodule

bind stepalu stepalu_chk #(.DW(DW), .OPW(OPW), .CNTW(CNTW), .CHKW(CHKW)) u_chk (.*);

// File: tb/tb_stepalu.sv
module tb_stepalu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus1_in = '0, bus2_in = '0;
   logic        a_ld = 0, b_ld = 0, fn_en = 0, ctl_en = 0, rng_chk = 0;
   logic [3:0]  fn_code = '0, ctl = '0;
   logic [7:0]  uop = '0;
   logic [31:0] acc_out, a_out, b_out;
   logic        cc0, cc1, range_err;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   stepalu dut (
      .clk(clk), .rst_n(rst_n), .bus1_in(bus1_in), .bus2_in(bus2_in),
      .a_ld(a_ld), .b_ld(b_ld), .fn_en(fn_en), .fn_code(fn_code),
      .uop(uop), .ctl(ctl), .ctl_en(ctl_en), .rng_chk(rng_chk),
      .acc_out(acc_out), .a_out(a_out), .b_out(b_out),
      .cc0(cc0), .cc1(cc1), .range_err(range_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic op(input logic la, input logic [31:0] va, input logic lb,
                     input logic [31:0] vb, input logic en, input logic [3:0] f,
                     input logic [7:0] u, input logic [3:0] c, input logic ce,
                     input logic rc);
      a_ld = la; bus1_in = va; b_ld = lb; bus2_in = vb;
      fn_en = en; fn_code = f; uop = u; ctl = c; ctl_en = ce; rng_chk = rc;
      @(posedge clk); #1;
      a_ld = 0; b_ld = 0; fn_en = 0; ctl_en = 0; rng_chk = 0;
      fn_code = '0; ctl = '0; uop = '0; bus1_in = '0; bus2_in = '0;
   endtask

   task automatic ld(input logic [31:0] va, input logic [31:0] vb);
      op(1, va, 1, vb, 0, 4'h0, 8'h00, 4'h0, 0, 0);
   endtask

   task automatic run(input logic [3:0] f, input logic [7:0] u);
      op(0, 0, 0, 0, 1, f, u, 4'h0, 0, 0);
   endtask

   task automatic t_reset;
      chk("R1 acc", acc_out, 32'h0);
      chk("R1 a", a_out, 32'h0);
      chk("R1 b", b_out, 32'h0);
      chk("R1 flags/err", {29'h0, cc0, cc1, range_err}, 32'h0);
   endtask

   task automatic t_basic;
      ld(32'd100, 32'd7);
      chk("R2 a load", a_out, 32'd100);
      chk("R2 b load", b_out, 32'd7);
      run(4'h0, 0); chk("R3 add", acc_out, 32'd107);
      chk("R7 flags add", {30'h0, cc0, cc1}, 32'h2);
      run(4'h1, 0); chk("R3 sub", acc_out, 32'd93);
      run(4'h2, 0); chk("R3 and", acc_out, 32'd4);
      run(4'h3, 0); chk("R3 or", acc_out, 32'd103);
      run(4'h4, 0); chk("R3 xor", acc_out, 32'd99);
      ld(32'd5, 32'd5);
      run(4'h1, 0); chk("R7 zero result", {acc_out[1:0], cc0, cc1}, 4'h0);
   endtask

   task automatic t_shift;
      ld(32'h8000_0001, 32'd3);
      run(4'h5, 0); chk("R4 sll", acc_out, 32'h0000_0008);
      run(4'h6, 0); chk("R4 srl", acc_out, 32'h1000_0000);
      run(4'h7, 0); chk("R4 sra", acc_out, 32'hF000_0000);
      chk("R7 negative flag", {30'h0, cc0, cc1}, 32'h3);
   endtask

   task automatic t_extra;
      ld(32'd3, 32'd10);
      run(4'h9, 0); chk("R5 rsub", acc_out, 32'd7);
      run(4'hA, 0); chk("R5 nega", acc_out, 32'hFFFF_FFFD);
      run(4'hB, 0); chk("R5 negb", acc_out, 32'hFFFF_FFF6);
      run(4'h8, 0); chk("R6 nop acc", acc_out, 32'hFFFF_FFF6);
      chk("R6 nop flags", {30'h0, cc0, cc1}, 32'h3);
      op(0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 0);
      chk("R6 no enable", acc_out, 32'hFFFF_FFF6);
      chk("R6 no enable a", a_out, 32'd3);
   endtask

   task automatic t_sha;
      ld(32'd5, 32'd5);
      run(4'h1, 0);                      // acc=0, cc1=0
      ld(32'h10, 32'd0);
      run(4'hC, 8'hFF);
      chk("R8 left fill one", a_out, 32'h21);
      chk("R8 flags new a", {30'h0, cc0, cc1}, 32'h2);
      chk("R8 acc kept", acc_out, 32'h0);
      run(4'hC, 8'h02); chk("R8 right 2", a_out, 32'h8);
      ld(32'd1, 32'd0);
      run(4'hC, 8'h01); chk("R8 right to zero", {a_out[30:0], cc0}, 32'h0);
      ld(32'd3, 32'd0);
      run(4'hA, 0);                      // cc1=1
      run(4'hC, 8'hFF);
      chk("R8 left fill zero", a_out, 32'h6);
      chk("R8 flags after fill zero", {30'h0, cc0, cc1}, 32'h2);
   endtask

   task automatic t_shb;
      logic [1:0] fl;
      ld(32'd0, 32'd1);
      fl = {cc0, cc1};
      run(4'hD, 8'd16); chk("R9 left 16", b_out, 32'h0001_0000);
      run(4'hD, 8'hF0); chk("R9 right 16", b_out, 32'h1);
      run(4'hD, 8'h01); chk("R9 left 1", b_out, 32'h2);
      run(4'hD, 8'hFF); chk("R9 right 1", b_out, 32'h1);
      chk("R9 flags kept", {30'h0, cc0, cc1}, {30'h0, fl});
   endtask

   task automatic t_dcnt;
      run(4'hE, 8'd17);
      for (int i = 1; i <= 16; i++) begin
         run(4'hF, 0);
         if (!cc0 || cc1) begin
            chk("R10 early zero", {30'h0, cc0, cc1}, 32'h2);
         end
      end
      total++;
      run(4'hF, 0); chk("R10 17th decrement", {30'h0, cc0, cc1}, 32'h0);
      run(4'hF, 0); chk("R10 wrap", {30'h0, cc0, cc1}, 32'h3);
   endtask

   task automatic t_ctl;
      ld(32'd10, 32'd20);
      run(4'h0, 0); chk("R3 pre ctl", acc_out, 32'd30);
      ld(32'd6, 32'd20);
      op(0, 0, 0, 0, 1, 4'h0, 0, 4'b1101, 1, 0);
      chk("R11 cond B off", acc_out, 32'd30);
      ld(32'd7, 32'd20);
      op(0, 0, 0, 0, 1, 4'h0, 0, 4'b1101, 1, 0);
      chk("R11 acc feedback", acc_out, 32'd50);
      op(0, 0, 0, 0, 1, 4'h0, 0, 4'b0010, 1, 0);
      chk("R11 inhibit B", acc_out, 32'd7);
      op(0, 0, 0, 0, 1, 4'h1, 0, 4'b0001, 1, 0);
      chk("R11 inhibit A", acc_out, 32'hFFFF_FFEC);
      op(0, 0, 0, 0, 1, 4'h0, 0, 4'b1111, 0, 0);
      chk("R11 disabled", acc_out, 32'd27);
   endtask

   task automatic t_range;
      ld(32'h0000_7FFF, 32'hFFFF_8000);
      op(0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 1);
      chk("R12 in range", {31'h0, range_err}, 32'h0);
      ld(32'h0001_0000, 32'd1);
      op(0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 1);
      chk("R12 out of range", {31'h0, range_err}, 32'h1);
      ld(32'd1, 32'd1);
      chk("R12 sticky", {31'h0, range_err}, 32'h1);
   endtask

   task automatic t_collide;
      logic [1:0] fl;
      ld(32'h8, 32'h4);
      run(4'h0, 0);                      // flags 10
      fl = {cc0, cc1};
      op(1, 32'h55, 0, 0, 1, 4'hC, 8'h01, 4'h0, 0, 0);
      chk("R2 load beats A shift", a_out, 32'h55);
      chk("R2 A shift dropped flags", {30'h0, cc0, cc1}, {30'h0, fl});
      op(0, 0, 1, 32'h33, 1, 4'hD, 8'h04, 4'h0, 0, 0);
      chk("R2 load beats B shift", b_out, 32'h33);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset;
      t_basic;
      t_shift;
      t_extra;
      t_sha;
      t_shb;
      t_dcnt;
      t_ctl;
      t_collide;
      t_range;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule